// File: doc/BRIEF.md
# Noise-Shaped Phase Sine Synthesizer

This core produces a digital sine wave whose frequency is set by a 16-bit tuning word. A 16-bit phase register adds the tuning word on every enabled clock and wraps freely. The top 12 bits of that phase do not go straight to the sine table. A single-stage, fourth-order error-feedback loop first cuts them to an 8-bit table address. The four discarded low bits are not simply dropped. Their error is fed back so that the truncation noise moves toward high frequencies. This lets a 256-entry table do the work of a 4096-entry one.

The table is built at elaboration by a constant function and holds one full period of a signed 12-bit sine. The output is a registered amplitude with a valid flag. The flag rises once the first phase sample has passed through the pipeline. An enable input freezes the whole datapath, and a synchronous reset returns it to phase zero.

Top module: `nsdds_core`

## Requirements
- R1: On every rising edge with `en` high and `rst` low, the phase register becomes (phase + `ftw`) mod 65536.
- R2: The shaper takes x = phase[15:4]. With e1..e4 being the last four stored errors (e1 newest, each 0..15), it forms v = x + 4·e1 − 6·e2 + 4·e3 − e4. It stores the new error (v mod 16, in 0..15) and produces the address floor(v/16) mod 256.
- R3: When v falls below 0 or reaches 4096 or more, the table address wraps modulo 256 and does not saturate.
- R4: Table entry k is round(2047·sin(2πk/256)) in two's complement, so the output peaks are +2047 (k=64) and −2047 (k=192).
- R5: The address formed from the phase held before enabled edge n is registered at edge n. The amplitude for that address is registered at the next enabled edge, giving a fixed two-stage latency after the phase register.
- R6: `amp_valid` is low after reset and rises at the second enabled edge after reset. It then stays high until the next reset.
- R7: A synchronous reset clears the phase, the four error registers, the address, `amp` and `amp_valid` to zero.
- R8: While `en` is low, the phase, error registers, `amp` and `amp_valid` hold their values.
- R9: With `ftw` zero from reset onward, `amp` stays 0 on every cycle.
- R10: Each registered address lies within ±8 (mod 256) of phase[15:8] taken from the phase that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the datapath when high |
| ftw | input | 16 | Frequency tuning word |
| amp | output | 12 | Signed sine amplitude |
| amp_valid | output | 1 | Amplitude is meaningful |

## Verification
The bench drives tuning words whose low bits are nonzero, which keeps the feedback active. A design with a wrong coefficient sign or with the error taken before the sum would produce addresses that drift from the reference within a few cycles. Negative and near-full-scale tuning words push v past both ends of its range. A saturating address would then flatten the waveform at the wrap instead of continuing it. A tuning word of 0x1000 steps exactly across the table peaks and checks the ±2047 entries and the rounding. Reset mid-run and pauses in `en` catch a valid flag or latency that counts raw clocks instead of enabled ones.

// File: rtl/nsdds_core.sv
`timescale 1ns/1ps
module nsdds_core #(
  parameter int PW   = 16,
  parameter int TRIM = 4,
  parameter int DW   = 12,
  parameter int PEAK = 2047
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] ftw,
  output logic [DW-1:0] amp,
  output logic          amp_valid
);
  localparam int XW = PW - TRIM;
  localparam int AW = XW - TRIM;
  localparam int TN = 1 << AW;
  localparam int FW = TRIM + 6;
  localparam int VW = XW + 2;

  typedef logic [DW-1:0] rom_t [TN];

  function automatic rom_t build_rom();
    rom_t t;
    for (int k = 0; k < TN; k++) begin
      real s;
      int  r;
      s = PEAK * $sin(2.0 * 3.14159265358979 * k / TN);
      r = (s >= 0.0) ? $rtoi(s + 0.5) : $rtoi(s - 0.5);
      t[k] = DW'(r);
    end
    return t;
  endfunction

  localparam rom_t ROM = build_rom();

  logic [PW-1:0]   acc;
  logic [TRIM-1:0] e1, e2, e3, e4;
  logic [AW-1:0]   addr_q;
  logic            addr_ok;
  logic [DW-1:0]   amp_q;

  logic signed [FW-1:0] fb;
  logic signed [VW-1:0] v;

  assign fb = $signed(FW'(e1) << 2) - $signed(FW'(e2) * FW'(6))
            + $signed(FW'(e3) << 2) - $signed(FW'(e4));
  assign v  = $signed({2'b00, acc[PW-1:TRIM]}) + {{(VW-FW){fb[FW-1]}}, fb};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      e1        <= '0;
      e2        <= '0;
      e3        <= '0;
      e4        <= '0;
      addr_q    <= '0;
      addr_ok   <= 1'b0;
      amp_q     <= '0;
      amp_valid <= 1'b0;
    end else if (en) begin
      acc       <= acc + ftw;
      e4        <= e3;
      e3        <= e2;
      e2        <= e1;
      e1        <= v[TRIM-1:0];
      addr_q    <= v[XW-1:TRIM];
      addr_ok   <= 1'b1;
      amp_q     <= ROM[addr_q];
      amp_valid <= addr_ok;
    end
  end

  assign amp = amp_q;

  // R1
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> acc == PW'($past(acc) + $past(ftw)));

  // R7
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (acc == '0) && (amp_q == '0) && !amp_valid && (e1 == '0) && (e4 == '0));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc) && $stable(amp_q) && $stable(amp_valid) && $stable(e1));

  // R6
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    amp_valid |=> amp_valid);

  // R10
  addr_near_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> AW'(AW'(addr_q - $past(acc[PW-1:PW-AW])) + AW'(8)) <= AW'(16));
endmodule

// File: tb/tb_nsdds_core.sv
`timescale 1ns/1ps
module tb_nsdds_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] ftw = '0;
  logic [11:0] amp;
  logic        amp_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  nsdds_core dut (.clk(clk), .rst(rst), .en(en), .ftw(ftw), .amp(amp), .amp_valid(amp_valid));

  always #10 clk = ~clk;

  int sine [256];
  initial begin
    for (int k = 0; k < 256; k++) begin
      real s;
      s = 2047.0 * $sin(2.0 * 3.14159265358979 * k / 256.0);
      sine[k] = (s >= 0.0) ? $rtoi(s + 0.5) : $rtoi(s - 0.5);
    end
  end

  int m_ph = 0, m_addr = 0, m_amp = 0, m_val = 0, m_aok = 0;
  int m_err [$] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_addr = 0; m_amp = 0; m_val = 0; m_aok = 0;
      m_err = '{0, 0, 0, 0};
    end else if (en) begin
      int x, vv, rem, y;
      x   = m_ph / 16;
      vv  = x + 4*m_err[0] - 6*m_err[1] + 4*m_err[2] - m_err[3];
      rem = ((vv % 16) + 16) % 16;
      y   = (vv - rem) / 16;
      m_amp  = sine[m_addr];
      m_val  = m_aok;
      m_aok  = 1;
      m_addr = ((y % 256) + 256) % 256;
      m_err.push_front(rem);
      void'(m_err.pop_back());
      m_ph = (m_ph + ftw) % 65536;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check($signed(amp) == m_amp, "R2 R3 R5 R10 amp", $signed(amp), m_amp);
      check(amp_valid == m_val, "R6 valid", amp_valid, m_val);
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int hi, lo;
    logic [11:0] held;
    logic hv;
    run(3);
    // R7: reset state
    check(amp == 0 && amp_valid == 0, "R7 reset", {amp_valid, amp}, 0);
    rst = 0; en = 1; ftw = 16'h0000;
    for (int i = 0; i < 12; i++) begin
      run(1);
      check(amp == 0, "R9 zero tuning", $signed(amp), 0);
    end
    // R4: peaks via exact table steps
    ftw = 16'h1000; hi = 0; lo = 0;
    for (int i = 0; i < 40; i++) begin
      run(1);
      if ($signed(amp) == 2047) hi++;
      if ($signed(amp) == -2047) lo++;
    end
    check(hi > 0, "R4 positive peak", hi, 1);
    check(lo > 0, "R4 negative peak", lo, 1);
    ftw = 16'h0123; run(300);
    // R8: pause
    en = 0; run(1); held = amp; hv = amp_valid;
    for (int i = 0; i < 6; i++) begin
      ftw = 16'(i * 977 + 5);
      run(1);
      check(amp == held && amp_valid == hv, "R8 hold", $signed(amp), $signed(held));
    end
    en = 1; ftw = 16'hFFF7; run(300);
    ftw = 16'h7FFF; run(100);
    for (int i = 0; i < 60; i++) begin
      en = (i % 3) != 0; ftw = 16'h0A5B; run(1);
    end
    en = 1;
    // R1 R3: wrap with a large word
    ftw = 16'hF00D; run(200);
    rst = 1; run(1);
    check(amp == 0 && amp_valid == 0, "R7 mid reset", {amp_valid, amp}, 0);
    rst = 0; en = 1; ftw = 16'h0401;
    run(1);
    check(amp_valid == 0, "R6 first edge", amp_valid, 0);
    run(1);
    check(amp_valid == 1, "R6 second edge", amp_valid, 1);
    run(200);
    finish_up();
  end
endmodule